// File: doc/BRIEF.md
# Packed Negative Multiply-Add Operand Router

This block sits in front of a bank of single-precision fused multiply-add lanes and handles all of the per-instruction plumbing for a packed negative multiply-add. It receives three 512-bit operand vectors: the destination, which also serves as a source, a second source and a third source. It picks which operand takes which role in each lane. It flips the sign of the multiplicand so that an external lane computing plain `a*b+c` yields `-(x*y)+z`. It also chooses the rounding mode the lanes use.

When every lane result has come back, the block assembles the final destination vector. Lanes that are masked off either keep their old value or are cleared, and every lane at or above the active vector length is cleared. The block also reports the OR of the exception flags of the lanes that were actually written. A short encoding allows only 128-bit and 256-bit lengths and has no masking or broadcast. An extended encoding adds masking, broadcast of the third source from memory, and a per-instruction rounding override.

A transaction is accepted on `in_valid` while `in_ready` is high. The lanes see `lane_go` together with stable operands until `lane_done`. The result is presented with a one-cycle `res_valid` pulse and held until the next result.

Top module: `pfnma_route`

## Requirements
- R1: With `form_sel`=0 (order 1-3-2), each active lane multiplies the destination lane by the third-source lane and adds the second-source lane (multiplicand role on `lane_a`, multiplier on `lane_b`, addend on `lane_c`).
- R2: With `form_sel`=1 (order 2-1-3), each active lane multiplies the second source by the destination and adds the third source.
- R3: With `form_sel`=2 or 3 (order 2-3-1), each active lane multiplies the second source by the third source and adds the destination.
- R4: The multiplicand is driven with its bit 31 inverted, which negates the product. The multiplier and the addend pass unchanged.
- R5: `vlen_sel` 0, 1 and 2/3 give 4, 8 and 16 lanes. Lane j is bits 32j+31:32j. Under the short encoding (`enc_ext`=0), a length of 2/3 acts as 8 lanes. In the result, every lane at or above the lane count is zero.
- R6: When `enc_ext`, `bcast` and `s3_mem` are all 1, bits 31:0 of `src3_in` supply the third-source role in every lane. Otherwise `bcast` has no effect.
- R7: When `enc_ext` and `mask_en` are both 1, an in-range lane whose `kmask` bit is 0 is inactive. It keeps its old destination value when `zero_mask`=0, and it is zero when `zero_mask`=1. Inactive lanes drive zero operands and show 0 on `lane_act`. Otherwise every in-range lane is active.
- R8: `lane_rm` equals `rc_instr` only when `enc_ext`=1, the effective length is 16 lanes, `bcast`=1 and `s3_mem`=0. In all other cases it equals `rc_glob`. The encoding is 00 nearest-even, 01 toward minus infinity, 10 toward plus infinity, 11 toward zero.
- R9: `res_flags` is the OR of the 5-bit `lane_flags` fields (lane j at bits 5j+4:5j), taken over active lanes only.
- R10: `in_ready` is high only when idle. Once a transaction is accepted, `lane_go` stays high with stable operands until `lane_done`, and input changes are ignored during that time. `res_dst`/`res_flags` update on the edge where `lane_go` and `lane_done` are both high. `res_valid` is high for exactly the following cycle, and the result then holds.
- R11: Reset (active-low `rst_n`) gives `in_ready`=1, `lane_go`=0, `res_valid`=0 and a zero `res_dst`, and it abandons any transaction in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block idle, request accepted |
| dst_in | input | 512 | Destination vector (also a source) |
| src2_in | input | 512 | Second source vector |
| src3_in | input | 512 | Third source vector |
| form_sel | input | 2 | Operand order select |
| vlen_sel | input | 2 | Vector length select |
| enc_ext | input | 1 | 1 = extended encoding, 0 = short encoding |
| bcast | input | 1 | Broadcast / rounding-override bit |
| s3_mem | input | 1 | Third source comes from memory |
| mask_en | input | 1 | Write mask present |
| zero_mask | input | 1 | 1 = zeroing, 0 = merging |
| kmask | input | 16 | Per-lane write mask |
| rc_glob | input | 2 | Global rounding mode |
| rc_instr | input | 2 | Per-instruction rounding mode |
| lane_go | output | 1 | Operands valid at the lanes |
| lane_a | output | 512 | Negated multiplicand per lane |
| lane_b | output | 512 | Multiplier per lane |
| lane_c | output | 512 | Addend per lane |
| lane_act | output | 16 | Lane active |
| lane_rm | output | 2 | Rounding mode for the lanes |
| lane_done | input | 1 | All lane results valid |
| lane_res | input | 512 | Lane results |
| lane_flags | input | 80 | Per-lane exception flags |
| res_valid | output | 1 | Result pulse |
| res_dst | output | 512 | Final destination vector |
| res_flags | output | 5 | ORed flags of active lanes |

## Verification
The bench builds the block with its defaults: 16 lanes of 32 bits and 5 flag bits per lane. This is the only configuration in which all three lane counts, the broadcast from lane 0, the rounding override at full width and the short-encoding clamp from 16 lanes to 8 can all be reached. Because the lanes are full-width, a 16-bit mask pattern can mix kept, cleared and written lanes within one vector. The flag rotation makes the ORed flags depend on exactly which lanes were active.

// File: rtl/pfnma_pkg.sv
package pfnma_pkg;

    typedef enum logic [1:0] {
        FORM_132  = 2'd0,
        FORM_213  = 2'd1,
        FORM_231  = 2'd2,
        FORM_231B = 2'd3
    } form_e;

    typedef enum logic [1:0] {
        VL_128  = 2'd0,
        VL_256  = 2'd1,
        VL_512  = 2'd2,
        VL_512B = 2'd3
    } vlen_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } st_e;

endpackage

// File: rtl/pfnma_ctl.sv
module pfnma_ctl #(
    parameter int LANES = 16
) (
    input  logic [1:0]       vlen,
    input  logic             enc_ext,
    input  logic             bcast,
    input  logic             s3_mem,
    input  logic             mask_en,
    input  logic [LANES-1:0] kmask,
    input  logic [1:0]       rc_glob,
    input  logic [1:0]       rc_instr,
    output logic [LANES-1:0] lim,
    output logic [LANES-1:0] on,
    output logic             bc_use,
    output logic [1:0]       rm
);
    import pfnma_pkg::*;

    localparam int CW   = $clog2(LANES + 1);
    localparam int N128 = LANES / 4;
    localparam int N256 = LANES / 2;

    vlen_e          vl_eff;
    logic           full_w;
    logic [CW-1:0]  cnt;
    logic           masking;

    always_comb begin
        vl_eff = vlen_e'(vlen);
        if (!enc_ext && (vl_eff == VL_512 || vl_eff == VL_512B)) begin
            vl_eff = VL_256;
        end
        full_w = (vl_eff == VL_512) || (vl_eff == VL_512B);
        case (vl_eff)
            VL_128:  cnt = CW'(N128);
            VL_256:  cnt = CW'(N256);
            default: cnt = CW'(LANES);
        endcase
        masking = enc_ext && mask_en;
        bc_use  = enc_ext && bcast && s3_mem;
        rm      = (enc_ext && full_w && bcast && !s3_mem) ? rc_instr : rc_glob;
    end

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        assign lim[j] = (CW'(j) < cnt);
        assign on[j]  = lim[j] && (!masking || kmask[j]);
    end

endmodule

// File: rtl/pfnma_lane_sel.sv
module pfnma_lane_sel #(
    parameter int W = 32
) (
    input  logic [1:0]   form,
    input  logic         on,
    input  logic [W-1:0] d,
    input  logic [W-1:0] s2,
    input  logic [W-1:0] s3,
    output logic [W-1:0] a,
    output logic [W-1:0] b,
    output logic [W-1:0] c
);
    import pfnma_pkg::*;

    logic [W-1:0] m1, m2, ad;

    always_comb begin
        case (form_e'(form))
            FORM_132: begin m1 = d;  m2 = s3; ad = s2; end
            FORM_213: begin m1 = s2; m2 = d;  ad = s3; end
            default:  begin m1 = s2; m2 = s3; ad = d;  end
        endcase
        // negating the multiplicand negates the product
        a = on ? {~m1[W-1], m1[W-2:0]} : '0;
        b = on ? m2 : '0;
        c = on ? ad : '0;
    end

endmodule

// File: rtl/pfnma_wb.sv
module pfnma_wb #(
    parameter int LANES = 16,
    parameter int W     = 32,
    parameter int FW    = 5
) (
    input  logic [LANES-1:0]    lim,
    input  logic [LANES-1:0]    on,
    input  logic                zero,
    input  logic [LANES*W-1:0]  old,
    input  logic [LANES*W-1:0]  res,
    input  logic [LANES*FW-1:0] flg_in,
    output logic [LANES*W-1:0]  dst,
    output logic [FW-1:0]       flg
);
    logic [LANES*FW-1:0] fm;

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        assign dst[j*W +: W] = on[j] ? res[j*W +: W]
                             : ((lim[j] && !zero) ? old[j*W +: W] : '0);
        assign fm[j*FW +: FW] = on[j] ? flg_in[j*FW +: FW] : '0;
    end

    always_comb begin
        flg = '0;
        for (int j = 0; j < LANES; j++) begin
            flg = flg | fm[j*FW +: FW];
        end
    end

endmodule

// File: rtl/pfnma_route.sv
module pfnma_route #(
    parameter int LANES = 16,
    parameter int W     = 32,
    parameter int FW    = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [LANES*W-1:0]  dst_in,
    input  logic [LANES*W-1:0]  src2_in,
    input  logic [LANES*W-1:0]  src3_in,
    input  logic [1:0]          form_sel,
    input  logic [1:0]          vlen_sel,
    input  logic                enc_ext,
    input  logic                bcast,
    input  logic                s3_mem,
    input  logic                mask_en,
    input  logic                zero_mask,
    input  logic [LANES-1:0]    kmask,
    input  logic [1:0]          rc_glob,
    input  logic [1:0]          rc_instr,
    output logic                lane_go,
    output logic [LANES*W-1:0]  lane_a,
    output logic [LANES*W-1:0]  lane_b,
    output logic [LANES*W-1:0]  lane_c,
    output logic [LANES-1:0]    lane_act,
    output logic [1:0]          lane_rm,
    input  logic                lane_done,
    input  logic [LANES*W-1:0]  lane_res,
    input  logic [LANES*FW-1:0] lane_flags,
    output logic                res_valid,
    output logic [LANES*W-1:0]  res_dst,
    output logic [FW-1:0]       res_flags
);
    import pfnma_pkg::*;

    localparam int VW = LANES * W;

    typedef struct packed {
        st_e              st;
        logic [VW-1:0]    a;
        logic [VW-1:0]    b;
        logic [VW-1:0]    c;
        logic [VW-1:0]    old;
        logic [LANES-1:0] lim;
        logic [LANES-1:0] on;
        logic             zero;
        logic [1:0]       rm;
        logic [VW-1:0]    dst;
        logic [FW-1:0]    flg;
        logic             rv;
    } regs_t;

    regs_t cur_q, nxt_d;

    logic [LANES-1:0] lim_w, on_w;
    logic             bc_w;
    logic [1:0]       rm_w;
    logic [VW-1:0]    sel_a, sel_b, sel_c;
    logic [VW-1:0]    wb_dst;
    logic [FW-1:0]    wb_flg;

    pfnma_ctl #(.LANES(LANES)) i_ctl (
        .vlen     (vlen_sel),
        .enc_ext  (enc_ext),
        .bcast    (bcast),
        .s3_mem   (s3_mem),
        .mask_en  (mask_en),
        .kmask    (kmask),
        .rc_glob  (rc_glob),
        .rc_instr (rc_instr),
        .lim      (lim_w),
        .on       (on_w),
        .bc_use   (bc_w),
        .rm       (rm_w)
    );

    for (genvar j = 0; j < LANES; j++) begin : g_sel
        logic [W-1:0] s3_l;
        assign s3_l = bc_w ? src3_in[W-1:0] : src3_in[j*W +: W];
        pfnma_lane_sel #(.W(W)) i_sel (
            .form (form_sel),
            .on   (on_w[j]),
            .d    (dst_in[j*W +: W]),
            .s2   (src2_in[j*W +: W]),
            .s3   (s3_l),
            .a    (sel_a[j*W +: W]),
            .b    (sel_b[j*W +: W]),
            .c    (sel_c[j*W +: W])
        );
    end

    pfnma_wb #(.LANES(LANES), .W(W), .FW(FW)) i_wb (
        .lim    (cur_q.lim),
        .on     (cur_q.on),
        .zero   (cur_q.zero),
        .old    (cur_q.old),
        .res    (lane_res),
        .flg_in (lane_flags),
        .dst    (wb_dst),
        .flg    (wb_flg)
    );

    always_comb begin
        nxt_d    = cur_q;
        nxt_d.rv = 1'b0;
        case (cur_q.st)
            ST_IDLE: begin
                if (in_valid) begin
                    nxt_d.st   = ST_WAIT;
                    nxt_d.a    = sel_a;
                    nxt_d.b    = sel_b;
                    nxt_d.c    = sel_c;
                    nxt_d.old  = dst_in;
                    nxt_d.lim  = lim_w;
                    nxt_d.on   = on_w;
                    nxt_d.zero = zero_mask;
                    nxt_d.rm   = rm_w;
                end
            end
            default: begin
                if (lane_done) begin
                    nxt_d.st  = ST_IDLE;
                    nxt_d.dst = wb_dst;
                    nxt_d.flg = wb_flg;
                    nxt_d.rv  = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign in_ready  = (cur_q.st == ST_IDLE);
    assign lane_go   = (cur_q.st == ST_WAIT);
    assign lane_a    = cur_q.a;
    assign lane_b    = cur_q.b;
    assign lane_c    = cur_q.c;
    assign lane_act  = cur_q.on;
    assign lane_rm   = cur_q.rm;
    assign res_valid = cur_q.rv;
    assign res_dst   = cur_q.dst;
    assign res_flags = cur_q.flg;

    // R10: lanes keep their request until they answer
    p_go_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_go && !lane_done) |=> (lane_go && $stable(lane_a) && $stable(lane_b) && $stable(lane_c)));

    // R10: result pulse lasts one cycle
    p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R10: a result only follows a completed lane request
    p_res_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(lane_go && lane_done));

    // R8: short encoding always takes the global rounding mode
    p_short_rm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !enc_ext) |=> (lane_rm == $past(rc_glob)));

    // R7: short encoding never masks an in-range lane
    p_short_nomask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !enc_ext) |=> (lane_act == cur_q.lim));

    // R5: lanes beyond the vector length come out cleared
    for (genvar j = 0; j < LANES; j++) begin : g_chk
        p_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (res_valid && !cur_q.lim[j]) |-> (res_dst[j*W +: W] == '0));
    end

endmodule

// File: tb/test_pfnma_route.sv
module test_pfnma_route;
    localparam int LANES = 16;
    localparam int W     = 32;
    localparam int FW    = 5;
    localparam int VW    = LANES * W;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                in_valid = 1'b0;
    logic                in_ready;
    logic [VW-1:0]       dst_in = '0, src2_in = '0, src3_in = '0;
    logic [1:0]          form_sel = '0, vlen_sel = '0;
    logic                enc_ext = 1'b0, bcast = 1'b0, s3_mem = 1'b0;
    logic                mask_en = 1'b0, zero_mask = 1'b0;
    logic [LANES-1:0]    kmask = '0;
    logic [1:0]          rc_glob = '0, rc_instr = '0;
    logic                lane_go;
    logic [VW-1:0]       lane_a, lane_b, lane_c;
    logic [LANES-1:0]    lane_act;
    logic [1:0]          lane_rm;
    logic                lane_done = 1'b0;
    logic [VW-1:0]       lane_res = '0;
    logic [LANES*FW-1:0] lane_flags = '0;
    logic                res_valid;
    logic [VW-1:0]       res_dst;
    logic [FW-1:0]       res_flags;

    always #4 clk = ~clk;   // 125 MHz

    pfnma_route #(.LANES(LANES), .W(W), .FW(FW)) i_pfnma_route (.*);

    typedef struct packed {
        logic [1:0]  form;
        logic [1:0]  vlen;
        logic        ext;
        logic        bcast;
        logic        mem;
        logic        men;
        logic        zm;
        logic [15:0] k;
        logic [1:0]  rcg;
        logic [1:0]  rci;
        logic [4:0]  cnt;   // expected lane count
        logic [1:0]  rm;    // expected rounding mode
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'hFFFF, 2'd1, 2'd3, 5'd4,  2'd1},
        '{2'd1, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0000, 2'd2, 2'd0, 5'd8,  2'd2},
        '{2'd2, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h1234, 2'd3, 2'd1, 5'd8,  2'd3},
        '{2'd0, 2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0000, 2'd0, 2'd2, 5'd16, 2'd0},
        '{2'd1, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 2'd2, 2'd1, 5'd16, 2'd1},
        '{2'd2, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 2'd3, 2'd0, 5'd8,  2'd3},
        '{2'd3, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 16'h000A, 2'd0, 2'd3, 5'd4,  2'd0},
        '{2'd0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 16'hA5C3, 2'd2, 2'd3, 5'd16, 2'd2},
        '{2'd1, 2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0F0F, 2'd1, 2'd2, 5'd8,  2'd1},
        '{2'd2, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 2'd0, 2'd2, 5'd16, 2'd2},
        '{2'd1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0000, 2'd3, 2'd1, 5'd4,  2'd3}
    };

    int n_cmp = 0;
    int n_bad = 0;

    task automatic chk(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [VW-1:0] mkv(input int idx, input logic [31:0] base);
        logic [VW-1:0] v;
        for (int j = 0; j < LANES; j++) begin
            v[j*W +: W] = base + 32'(idx) * 32'h0103_0000 + 32'(j) * 32'h0000_0451;
        end
        return v;
    endfunction

    function automatic logic [W-1:0] fr(input logic [W-1:0] a, b, c);
        return (a ^ {b[7:0], b[W-1:8]}) + c + 32'd3;
    endfunction

    function automatic logic [FW-1:0] flag_of(input int j, input int rot);
        return FW'(1) << ((j + rot) % FW);
    endfunction

    task automatic model(input vec_t v, input int rot,
                         input logic [VW-1:0] d, s2, s3,
                         output logic [VW-1:0] ea, eb, ec, er, hi,
                         output logic [LANES-1:0] eact, output logic [FW-1:0] ef);
        ef = '0;
        for (int j = 0; j < LANES; j++) begin
            logic [W-1:0] dl, s2l, s3l, m1, m2, ad, ra, rb, rc;
            logic inr, on;
            dl  = d[j*W +: W];
            s2l = s2[j*W +: W];
            s3l = (v.ext && v.bcast && v.mem) ? s3[W-1:0] : s3[j*W +: W];
            inr = (j < int'(v.cnt));
            on  = inr && (!(v.ext && v.men) || v.k[j]);
            case (v.form)
                2'd0:    begin m1 = dl;  m2 = s3l; ad = s2l; end
                2'd1:    begin m1 = s2l; m2 = dl;  ad = s3l; end
                default: begin m1 = s2l; m2 = s3l; ad = dl;  end
            endcase
            ra = on ? (m1 ^ 32'h8000_0000) : '0;
            rb = on ? m2 : '0;
            rc = on ? ad : '0;
            ea[j*W +: W] = ra;
            eb[j*W +: W] = rb;
            ec[j*W +: W] = rc;
            eact[j] = on;
            er[j*W +: W] = on ? fr(ra, rb, rc) : ((inr && !v.zm) ? dl : '0);
            hi[j*W +: W] = inr ? '0 : '1;
            if (on) ef = ef | flag_of(j, rot);
        end
    endtask

    task automatic drive(input vec_t v, input logic [VW-1:0] d, s2, s3);
        dst_in = d; src2_in = s2; src3_in = s3;
        form_sel = v.form; vlen_sel = v.vlen; enc_ext = v.ext;
        bcast = v.bcast; s3_mem = v.mem; mask_en = v.men; zero_mask = v.zm;
        kmask = v.k; rc_glob = v.rcg; rc_instr = v.rci;
    endtask

    task automatic run_txn(input int idx, input vec_t v, input int extra, input bit intrude);
        logic [VW-1:0] d, s2, s3, ea, eb, ec, er, hi;
        logic [LANES-1:0] eact;
        logic [FW-1:0] ef;
        string ft, bt;
        d  = mkv(idx, 32'h3F80_0000);
        s2 = mkv(idx, 32'h4040_0001);
        s3 = mkv(idx, 32'hC0A0_0002);
        model(v, idx, d, s2, s3, ea, eb, ec, er, hi, eact, ef);
        ft = (v.form == 2'd0) ? "R1" : ((v.form == 2'd1) ? "R2" : "R3");
        bt = (v.ext && v.bcast && v.mem) ? "R6" : ft;
        @(negedge clk);
        drive(v, d, s2, s3);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R10 lane_go", VW'(lane_go), VW'(1));
        chk("R10 in_ready busy", VW'(in_ready), VW'(0));
        chk("R4 multiplicand", lane_a, ea);
        chk({bt, " multiplier"}, lane_b, eb);
        chk({bt, " addend"}, lane_c, ec);
        chk("R7 lane_act", VW'(lane_act), VW'(eact));
        chk("R8 lane_rm", VW'(lane_rm), VW'(v.rm));
        for (int w = 0; w < extra; w++) begin
            if (intrude) begin
                in_valid = 1'b1;
                dst_in   = ~d;
                form_sel = ~v.form;
                src3_in  = s2;
            end
            @(negedge clk);
            in_valid = 1'b0;
            chk("R10 held multiplicand", lane_a, ea);
            chk("R10 held addend", lane_c, ec);
            chk("R10 no early result", VW'(res_valid), VW'(0));
        end
        for (int j = 0; j < LANES; j++) begin
            lane_res[j*W +: W]    = fr(lane_a[j*W +: W], lane_b[j*W +: W], lane_c[j*W +: W]);
            lane_flags[j*FW +: FW] = flag_of(j, idx);
        end
        lane_done = 1'b1;
        @(negedge clk);
        lane_done = 1'b0;
        chk("R10 res_valid", VW'(res_valid), VW'(1));
        chk("R7 res_dst", res_dst, er);
        chk("R5 upper lanes", res_dst & hi, '0);
        chk("R9 res_flags", VW'(res_flags), VW'(ef));
        @(negedge clk);
        chk("R10 pulse end", VW'(res_valid), VW'(0));
        chk("R10 result held", res_dst, er);
        chk("R10 ready again", VW'(in_ready), VW'(1));
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 in_ready", VW'(in_ready), VW'(1));
        chk("R11 lane_go", VW'(lane_go), VW'(0));
        chk("R11 res_valid", VW'(res_valid), VW'(0));
        chk("R11 res_dst", res_dst, '0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            run_txn(i, VECS[i], 0, 1'b0);
        end

        // R10: long lane latency with requests offered while busy
        run_txn(20, VECS[7], 3, 1'b1);
        run_txn(21, VECS[3], 2, 1'b1);

        // R11: reset abandons an in-flight request and clears the result
        @(negedge clk);
        drive(VECS[4], mkv(30, 32'h1), mkv(30, 32'h2), mkv(30, 32'h3));
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R10 accepted before reset", VW'(lane_go), VW'(1));
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R11 in_ready after reset", VW'(in_ready), VW'(1));
        chk("R11 lane_go after reset", VW'(lane_go), VW'(0));
        chk("R11 res_dst after reset", res_dst, '0);
        chk("R11 res_flags after reset", VW'(res_flags), '0);

        // back in service after reset
        run_txn(31, VECS[8], 1, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule